// File: doc/BRIEF.md
# Rotating Register File with Loop Base

This block is a multi-ported register file for software-pipelined loops. A small base counter renames register addresses as they are used. The upper part of the register space is the rotating region. A logical number in that region is offset by the current base and wraps inside the region. The lower part is the fixed region, and its numbers reach storage unchanged. Each pulse of the loop-closing branch lowers the base by one. A value written under one logical name therefore appears one name higher after every later iteration. Each iteration of a pipelined loop then works on its own set of physical registers, and the loop body needs no copies.

A one-bit predicate file sits beside the data file. Its upper part rotates with the same base, taken modulo its own rotating size. The predicate that enables a pipeline stage therefore moves to the next stage on every loop branch. The block has two combinational data read ports, one data write port, one predicate read port and one predicate write port. It also takes a loop-branch pulse and a base clear. Instruction decode and the branch decision belong to other blocks.

Top module: `rrf_rotating_file`

## Requirements
- R1: A synchronous active-high `rst` sets the base to zero and clears every data register and every predicate to zero.
- R2: A data logical number below NREGS-NROT (the fixed region) selects the physical register with the same number, whatever the base.
- R3: A data logical number l at or above F = NREGS-NROT selects physical register F + ((l - F + base) mod NROT). A value written to rotating logical n is therefore read at logical F + ((n - F + k) mod NROT) after k loop branches.
- R4: Each cycle with `loop_br` high and `rrb_clr` low lowers the base by one. The base wraps from 0 to NROT-1.
- R5: A write in the same cycle as `loop_br` is mapped with the base value from before the decrement.
- R6: Logical data register 0 always reads zero. A write to it has no effect.
- R7: `rrb_clr` sets the base to zero on the next edge. It takes precedence over `loop_br` and leaves register and predicate contents unchanged.
- R8: A predicate number p at or above G = NPRED-NPROT selects physical predicate G + ((p - G + base) mod NPROT). A number below G selects predicate p directly. Predicate writes use the same mapping.
- R9: Reads are combinational from the current contents and base. A read in the same cycle as a write to the same location returns the old value, and the new value is visible from the next cycle. The two data read ports are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rrb_clr | input | 1 | Clear the rotation base |
| loop_br | input | 1 | Loop-closing branch pulse; lowers the base |
| rd_a_idx | input | $clog2(NREGS) | Read port A logical number |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | $clog2(NREGS) | Read port B logical number |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Data write enable |
| wr_idx | input | $clog2(NREGS) | Data write logical number |
| wr_data | input | DW | Data write value |
| pr_wr_en | input | 1 | Predicate write enable |
| pr_wr_idx | input | $clog2(NPRED) | Predicate write logical number |
| pr_wr_val | input | 1 | Predicate write value |
| pr_rd_idx | input | $clog2(NPRED) | Predicate read logical number |
| pr_rd_val | output | 1 | Predicate read value |

## Verification
The bench builds the block with NREGS=16, NROT=8, DW=16, NPRED=8 and NPROT=4. With these sizes the base wraps after eight branches, so a short run crosses the wrap many times. Random writes also cover every physical register, and the predicate rotation wraps after only four branches while the data base keeps counting. Index sums that run past the top of a region occur often in both files, so the modulo wrap of the mapping is checked at every base value.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    // Action on the rotation base for one cycle
    typedef enum logic [1:0] {
        BASE_HOLD = 2'd0,
        BASE_STEP = 2'd1,
        BASE_ZERO = 2'd2
    } base_op_e;

    // Which part of a register space a logical number falls in
    typedef enum logic {
        ZONE_FIXED = 1'b0,
        ZONE_ROT   = 1'b1
    } zone_e;

    // Clear wins over the loop step
    function automatic base_op_e pick_base_op(input logic clr, input logic step);
        if (clr)       return BASE_ZERO;
        else if (step) return BASE_STEP;
        else           return BASE_HOLD;
    endfunction

endpackage

// File: rtl/rrf_base_ctr.sv
module rrf_base_ctr
    import rrf_pkg::*;
#(
    parameter int NROT = 32,
    parameter int BW   = $clog2(NROT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [BW-1:0] base
);

    base_op_e op;

    always_comb op = pick_base_op(clr, step);

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
        end else begin
            case (op)
                BASE_ZERO: base <= '0;
                BASE_STEP: base <= base - BW'(1);
                default:   base <= base;
            endcase
        end
    end

    // R4
    base_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clr) |=> (base == $past(base) - BW'(1)));

    // R7
    base_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (base == '0));

    // R1
    base_rst_chk: assert property (@(posedge clk)
        rst |=> (base == '0));

endmodule

// File: rtl/rrf_map.sv
module rrf_map
    import rrf_pkg::*;
#(
    parameter int NENT = 64,
    parameter int NROT = 32,
    parameter int IW   = $clog2(NENT),
    parameter int RW   = $clog2(NROT)
) (
    input  logic [IW-1:0] log_idx,
    input  logic [RW-1:0] base,
    output logic [IW-1:0] phys
);

    localparam int NFIX = NENT - NROT;

    zone_e         zone;
    logic [RW-1:0] rot;

    always_comb begin
        zone = (int'(log_idx) >= NFIX) ? ZONE_ROT : ZONE_FIXED;
        rot  = RW'(log_idx - IW'(NFIX)) + base;
        phys = (zone == ZONE_ROT) ? (IW'(NFIX) + IW'(rot)) : log_idx;
    end

    // R3
    always_comb begin
        if (zone == ZONE_ROT) begin
            rot_zone_chk: assert (int'(phys) >= NFIX);
        end
    end

endmodule

// File: rtl/rrf_bank.sv
module rrf_bank #(
    parameter int NENT  = 64,
    parameter int W     = 32,
    parameter int NRD   = 2,
    parameter bit ZERO0 = 1'b1,
    parameter int IW    = $clog2(NENT)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IW-1:0]           widx,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][IW-1:0]  r_idx,
    output logic [NRD-1:0][W-1:0]   r_data
);

    logic [W-1:0] mem [NENT];
    logic         wr_ok;

    always_comb wr_ok = we && !(ZERO0 && (widx == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NENT; e++) mem[e] <= '0;
        end else if (wr_ok) begin
            mem[widx] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if (ZERO0 && (r_idx[g] == '0)) r_data[g] = '0;
            else                           r_data[g] = mem[r_idx[g]];
        end
    end

endmodule

// File: rtl/rrf_rotating_file.sv
module rrf_rotating_file
    import rrf_pkg::*;
#(
    parameter int NREGS = 64,   // power of two
    parameter int NROT  = 32,   // power of two, below NREGS
    parameter int DW    = 32,
    parameter int NPRED = 16,   // power of two
    parameter int NPROT = 8     // power of two, at most NROT, below NPRED
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rrb_clr,
    input  logic                      loop_br,
    input  logic [$clog2(NREGS)-1:0]  rd_a_idx,
    output logic [DW-1:0]             rd_a_data,
    input  logic [$clog2(NREGS)-1:0]  rd_b_idx,
    output logic [DW-1:0]             rd_b_data,
    input  logic                      wr_en,
    input  logic [$clog2(NREGS)-1:0]  wr_idx,
    input  logic [DW-1:0]             wr_data,
    input  logic                      pr_wr_en,
    input  logic [$clog2(NPRED)-1:0]  pr_wr_idx,
    input  logic                      pr_wr_val,
    input  logic [$clog2(NPRED)-1:0]  pr_rd_idx,
    output logic                      pr_rd_val
);

    localparam int IW  = $clog2(NREGS);
    localparam int PW  = $clog2(NPRED);
    localparam int BW  = $clog2(NROT);
    localparam int PRW = $clog2(NPROT);
    localparam int NDP = 3;   // data ports: read A, read B, write
    localparam int NPP = 2;   // predicate ports: read, write

    logic [BW-1:0] base;

    rrf_base_ctr #(.NROT(NROT), .BW(BW)) u_base (
        .clk  (clk),
        .rst  (rst),
        .clr  (rrb_clr),
        .step (loop_br),
        .base (base)
    );

    // Data address mapping, one mapper per port
    logic [NDP-1:0][IW-1:0] d_log;
    logic [NDP-1:0][IW-1:0] d_phys;

    always_comb d_log = {wr_idx, rd_b_idx, rd_a_idx};

    for (genvar g = 0; g < NDP; g++) begin : g_dmap
        rrf_map #(.NENT(NREGS), .NROT(NROT), .IW(IW), .RW(BW)) u_map (
            .log_idx (d_log[g]),
            .base    (base),
            .phys    (d_phys[g])
        );
    end

    // Predicate address mapping on the low bits of the same base
    logic [NPP-1:0][PW-1:0] p_log;
    logic [NPP-1:0][PW-1:0] p_phys;

    always_comb p_log = {pr_wr_idx, pr_rd_idx};

    for (genvar g = 0; g < NPP; g++) begin : g_pmap
        rrf_map #(.NENT(NPRED), .NROT(NPROT), .IW(PW), .RW(PRW)) u_map (
            .log_idx (p_log[g]),
            .base    (base[PRW-1:0]),
            .phys    (p_phys[g])
        );
    end

    // Storage
    logic [1:0][DW-1:0] d_rdata;
    logic [0:0][0:0]    p_rdata;

    rrf_bank #(.NENT(NREGS), .W(DW), .NRD(2), .ZERO0(1'b1), .IW(IW)) u_dbank (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en),
        .widx   (d_phys[2]),
        .wdata  (wr_data),
        .r_idx  (d_phys[1:0]),
        .r_data (d_rdata)
    );

    rrf_bank #(.NENT(NPRED), .W(1), .NRD(1), .ZERO0(1'b0), .IW(PW)) u_pbank (
        .clk    (clk),
        .rst    (rst),
        .we     (pr_wr_en),
        .widx   (p_phys[1]),
        .wdata  (pr_wr_val),
        .r_idx  (p_phys[0:0]),
        .r_data (p_rdata)
    );

    always_comb begin
        rd_a_data = d_rdata[0];
        rd_b_data = d_rdata[1];
        pr_rd_val = p_rdata[0][0];
    end

    // R6
    zero_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0));

    // R9
    hold_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !loop_br && !rrb_clr) |=> ($stable(rd_a_idx) |-> $stable(rd_a_data)));

endmodule

// File: tb/sim_rrf_rotating_file.sv
`timescale 1ns/1ps
module sim_rrf_rotating_file;

    localparam int NREGS = 16;
    localparam int NROT  = 8;
    localparam int DW    = 16;
    localparam int NPRED = 8;
    localparam int NPROT = 4;
    localparam int IW    = $clog2(NREGS);
    localparam int PW    = $clog2(NPRED);
    localparam int NFIX  = NREGS - NROT;
    localparam int PFIX  = NPRED - NPROT;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          rst, rrb_clr, loop_br, wr_en, pr_wr_en, pr_wr_val;
    logic [IW-1:0] rd_a_idx, rd_b_idx, wr_idx;
    logic [DW-1:0] wr_data, rd_a_data, rd_b_data;
    logic [PW-1:0] pr_wr_idx, pr_rd_idx;
    logic          pr_rd_val;

    rrf_rotating_file #(
        .NREGS(NREGS), .NROT(NROT), .DW(DW), .NPRED(NPRED), .NPROT(NPROT)
    ) u0 (
        .clk(clk), .rst(rst), .rrb_clr(rrb_clr), .loop_br(loop_br),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pr_wr_en(pr_wr_en), .pr_wr_idx(pr_wr_idx), .pr_wr_val(pr_wr_val),
        .pr_rd_idx(pr_rd_idx), .pr_rd_val(pr_rd_val)
    );

    // Behavioural model
    int  regs  [NREGS];
    int  preds [NPRED];
    int  rrb;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    function automatic int dmap(int l);
        if (l < NFIX) return l;
        return NFIX + ((l - NFIX + rrb) % NROT);
    endfunction

    function automatic int pmap(int l);
        if (l < PFIX) return l;
        return PFIX + ((l - PFIX + (rrb % NPROT)) % NPROT);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Compare outputs mid-cycle, then advance the model with the edge
    task automatic cyc(input string tag);
        int ea, eb, ep;
        #2;
        ea = (rd_a_idx == 0) ? 0 : regs[dmap(int'(rd_a_idx))];
        eb = (rd_b_idx == 0) ? 0 : regs[dmap(int'(rd_b_idx))];
        ep = preds[pmap(int'(pr_rd_idx))];
        chk({tag, " port A"}, int'(rd_a_data), ea);
        chk({tag, " port B"}, int'(rd_b_data), eb);
        chk({tag, " predicate"}, int'(pr_rd_val), ep);
        @(posedge clk);
        if (rst) begin
            foreach (regs[i])  regs[i]  = 0;
            foreach (preds[i]) preds[i] = 0;
            rrb = 0;
        end else begin
            if (wr_en && wr_idx != 0) regs[dmap(int'(wr_idx))] = int'(wr_data);
            if (pr_wr_en) preds[pmap(int'(pr_wr_idx))] = int'(pr_wr_val);
            if (rrb_clr)      rrb = 0;
            else if (loop_br) rrb = (rrb + NROT - 1) % NROT;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 0; rrb_clr = 0; loop_br = 0; wr_en = 0; pr_wr_en = 0;
        pr_wr_val = 0; wr_idx = '0; wr_data = '0; pr_wr_idx = '0;
    endtask

    task automatic wr(input int idx, input int val);
        wr_en = 1; wr_idx = IW'(idx); wr_data = DW'(val);
    endtask

    initial begin
        #(20ns * 100000);
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        summary();
    end

    initial begin
        idle();
        rd_a_idx = '0; rd_b_idx = '0; pr_rd_idx = '0;
        rst = 1;
        repeat (2) @(posedge clk);
        foreach (regs[i])  regs[i]  = 0;
        foreach (preds[i]) preds[i] = 0;
        rrb = 0;
        @(negedge clk);
        idle();

        // R1: everything reads zero after reset
        rd_a_idx = 3; rd_b_idx = 12; pr_rd_idx = 6;
        cyc("R1");

        // R6: writes to register 0 are dropped
        wr(0, 'hBEEF); rd_a_idx = 0; cyc("R6");
        idle(); cyc("R6");

        // R2: fixed region unchanged by branches
        wr(5, 'h1234); cyc("R2");
        idle(); rd_a_idx = 5; loop_br = 1;
        for (int i = 0; i < 3; i++) cyc("R2");

        // R7: clear wins over branch, contents kept
        rrb_clr = 1; loop_br = 1; cyc("R7");
        idle(); rd_b_idx = 5; cyc("R7");

        // R3: value written at n is seen at n+3 after three branches
        wr(NFIX + 1, 'hA1); cyc("R3");
        wr(NFIX + 6, 'hB2); cyc("R3");
        idle(); loop_br = 1;
        for (int i = 0; i < 3; i++) cyc("R3");
        idle(); rd_a_idx = IW'(NFIX + 4); rd_b_idx = IW'(NFIX + 1); cyc("R3");

        // R4: base wraps from 0 to NROT-1
        rrb_clr = 1; cyc("R4");
        idle(); loop_br = 1; cyc("R4");
        idle(); wr(NFIX, 'hC3); cyc("R4");
        idle(); rrb_clr = 1; cyc("R4");
        idle(); rd_a_idx = IW'(NREGS - 1); rd_b_idx = IW'(NFIX); cyc("R4");

        // R5: write with branch uses pre-decrement base
        wr(NFIX + 2, 'hD4); loop_br = 1; cyc("R5");
        idle(); rd_a_idx = IW'(NFIX + 3); rd_b_idx = IW'(NFIX + 2); cyc("R5");

        // R8: predicates rotate with base modulo NPROT
        pr_wr_en = 1; pr_wr_idx = PW'(PFIX); pr_wr_val = 1; cyc("R8");
        pr_wr_idx = PW'(1); cyc("R8");
        idle(); loop_br = 1;
        for (int i = 0; i < 5; i++) begin
            pr_rd_idx = PW'(PFIX + ((i + 1) % NPROT));
            cyc("R8");
        end
        idle(); pr_rd_idx = PW'(1); cyc("R8");

        // R9: read during write sees old value; ports independent
        rd_a_idx = 3; rd_b_idx = 5; wr(3, 'h5A5A); cyc("R9");
        idle(); cyc("R9");

        // Random traffic checked against the model every cycle
        for (int i = 0; i < 600; i++) begin
            idle();
            wr_en     = ($urandom % 2) == 0;
            wr_idx    = IW'($urandom);
            wr_data   = DW'($urandom);
            loop_br   = ($urandom % 3) == 0;
            rrb_clr   = ($urandom % 29) == 0;
            pr_wr_en  = ($urandom % 3) == 0;
            pr_wr_idx = PW'($urandom);
            pr_wr_val = 1'($urandom);
            rd_a_idx  = IW'($urandom);
            rd_b_idx  = IW'($urandom);
            pr_rd_idx = PW'($urandom);
            cyc("R3 random");
        end

        idle(); rst = 1; cyc("R1");
        idle(); rd_a_idx = IW'(NFIX + 2); pr_rd_idx = PW'(PFIX); cyc("R1");

        done = 1;
        summary();
    end

endmodule